// File: doc/BRIEF.md
# Banked RAM Address Mapper

This block sits between a processor with a 16-bit address bus and a 128 KB RAM built from eight 16 KB banks. The logical address space is cut into four 16 KB windows, chosen by address bits 15:14. For each window a layout register names the physical bank behind it. The block forms the 17-bit RAM address from that 3-bit bank number and address bits 13:0. Reads and writes go through the same translation.

Software picks one of eight fixed layouts with an I/O output cycle. The upper address byte must be 7F hex, and the data byte must have 11 in its top two bits. The low three bits of that byte select the layout. The register cannot be read back. Five of the layouts are the usual ones: the identity layout, plus four that swap one extended bank into the second window. The other three remap more of the space. One puts banks 4 to 7 behind all four windows. The other two put bank 7 in the top window and bank 1 or bank 3 in the second window. This lets a program running from bank 7 copy data straight to or from the lower banks.

Top module: `bank_map_top`

## Requirements
- R1: After a synchronous active-high reset, layout 0 is selected. Window w (address bits 15:14) maps to bank w, so physAddr equals {1'b0, cpuAddr}.
- R2: physAddr bits 13:0 always equal cpuAddr bits 13:0, and physAddr bits 16:14 are the bank number.
- R3: On a rising edge where ioWr is 1, cpuAddr[15:8] is 8'h7F and cpuData[7:6] is 2'b11, the register captures cpuData[2:0] as the layout number.
- R4: An I/O write whose data byte has top bits other than 2'b11 leaves the layout unchanged.
- R5: A data byte of the 11xxxxxx form leaves the layout unchanged when the upper address byte is not 8'h7F or when ioWr is 0.
- R6: A captured layout governs translation from the cycle after the capturing edge. It holds until the next capture.
- R7: Layouts 4, 5, 6 and 7 map window 1 to bank 4, 5, 6 or 7 respectively. Windows 0, 2 and 3 map to banks 0, 2 and 3.
- R8: Layout 1 maps windows 0 to 3 to banks 0, 1, 2, 7.
- R9: Layout 2 maps windows 0 to 3 to banks 4, 5, 6, 7.
- R10: Layout 3 maps windows 0 to 3 to banks 0, 3, 2, 7.
- R11: Data bits 5:3 of a captured byte have no effect; for example, byte C9 selects the same layout as C1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 16 | Processor address, used for memory and I/O cycles |
| ioWr | input | 1 | I/O write strobe, active high, one clock per write |
| cpuData | input | 8 | Processor data bus during I/O writes |
| physAddr | output | 17 | Physical RAM address: bank number, then offset |

## Verification
The assertions assume that ioWr, cpuAddr and cpuData are stable around the rising edge. They also assume that reset is held from time zero until the first edges. The bench therefore changes inputs only just after a falling edge and holds reset high from the start. The bench writes one I/O write at a time. It then moves the address through every window while ioWr is low, so each translation check sees one settled layout.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int WIN_BITS  = 2;
  localparam int BANK_BITS = 3;
  localparam int SEL_BITS  = 3;
  localparam int NUM_WIN   = 1 << WIN_BITS;

  typedef struct packed {
    logic                cfgLoad;
    logic [SEL_BITS-1:0] cfgSel;
  } ctrlStrobe_t;

  // Bank placed behind a logical window for a given layout number.
  function automatic logic [BANK_BITS-1:0] mapBank(input logic [SEL_BITS-1:0] sel,
                                                    input logic [WIN_BITS-1:0] win);
    logic [BANK_BITS-1:0] ident;
    ident = {1'b0, win};
    case (sel)
      3'd0: mapBank = ident;
      3'd1: mapBank = (win == 2'd3) ? 3'd7 : ident;
      3'd2: mapBank = {1'b1, win};
      3'd3: mapBank = (win == 2'd1) ? 3'd3 : ((win == 2'd3) ? 3'd7 : ident);
      default: mapBank = (win == 2'd1) ? sel : ident;
    endcase
  endfunction
endpackage

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  PORT_HI = 8'h7F,
  parameter logic [1:0]  TAG     = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] cpuData,
  output ctrlStrobe_t       strb
);
  localparam int PORT_LSB = ADDR_W - 8;
  localparam int TAG_LSB  = DATA_W - 2;

  logic portHit;
  logic tagHit;

  assign portHit = (cpuAddr[ADDR_W-1:PORT_LSB] == PORT_HI);
  assign tagHit  = (cpuData[DATA_W-1:TAG_LSB] == TAG);

  always_comb begin
    strb.cfgLoad = ioWr && portHit && tagHit;
    strb.cfgSel  = cpuData[SEL_BITS-1:0];
  end

  // R5
  idle_bus_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ioWr |-> !strb.cfgLoad);
endmodule

// File: rtl/bank_map_dp.sv
module bank_map_dp
  import bank_map_pkg::*;
#(
  parameter int                  ADDR_W    = 16,
  parameter logic [SEL_BITS-1:0] RESET_SEL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [ADDR_W:0]   physAddr
);
  localparam int OFFS_W = ADDR_W - WIN_BITS;

  logic [SEL_BITS-1:0]  curSel;
  logic [BANK_BITS-1:0] bankOf [NUM_WIN];
  logic [WIN_BITS-1:0]  win;

  always_ff @(posedge clk) begin
    if (rst)               curSel <= RESET_SEL;
    else if (strb.cfgLoad) curSel <= strb.cfgSel;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign bankOf[w] = mapBank(curSel, w[WIN_BITS-1:0]);
  end

  assign win      = cpuAddr[ADDR_W-1:OFFS_W];
  assign physAddr = {bankOf[win], cpuAddr[OFFS_W-1:0]};

  // R6
  hold_layout_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.cfgLoad |=> $stable(curSel));

  // R3
  capture_layout_chk: assert property (@(posedge clk) disable iff (rst)
    strb.cfgLoad |=> (curSel == $past(strb.cfgSel)));

  // R10
  third_window_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (win == 2'd2 && curSel != 3'd2) |-> (physAddr[ADDR_W:OFFS_W] == 3'd2));

  // R9
  all_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (curSel == 3'd2) |-> physAddr[ADDR_W]);
endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
  import bank_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] cpuData,
  output logic [ADDR_W:0]   physAddr
);
  ctrlStrobe_t strb;

  bank_map_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .ioWr(ioWr),
    .cpuData(cpuData), .strb(strb));

  bank_map_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cpuAddr(cpuAddr), .physAddr(physAddr));

  // R4
  bad_tag_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ioWr && cpuData[DATA_W-1:DATA_W-2] != 2'b11) |-> !strb.cfgLoad);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    physAddr[ADDR_W-3:0] == cpuAddr[ADDR_W-3:0]);
endmodule

// File: tb/bank_map_top_bench.sv
module bank_map_top_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic        ioWr = 1'b0;
  logic [7:0]  cpuData = '0;
  logic [16:0] physAddr;
  int compared = 0;
  int mismatched = 0;

  always #(PERIOD/2) clk = ~clk;

  bank_map_top u_bank_map_top (.clk(clk), .rst(rst), .cpuAddr(cpuAddr), .ioWr(ioWr),
                               .cpuData(cpuData), .physAddr(physAddr));

  function automatic logic [2:0] expBank(input int lay, input int w);
    case (lay)
      0: return 3'(w);
      1: return (w == 3) ? 3'd7 : 3'(w);
      2: return 3'(4 + w);
      3: return (w == 1) ? 3'd3 : ((w == 3) ? 3'd7 : 3'(w));
      default: return (w == 1) ? 3'(lay) : 3'(w);
    endcase
  endfunction

  task automatic check(input logic [16:0] exp, input string req);
    compared++;
    if (physAddr !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpuAddr, physAddr, exp);
    end
  endtask

  // Walk every window with two offsets and compare against layout lay.
  task automatic checkLayout(input int lay, input string req);
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 2; k++) begin
        logic [13:0] offs;
        offs = (k == 0) ? 14'h0000 : 14'h3FFF - 14'(w * 37);
        @(negedge clk);
        cpuAddr = {2'(w), offs};
        #1;
        check({expBank(lay, w), offs}, req);
      end
    end
  endtask

  task automatic ioWrite(input logic [15:0] port, input logic [7:0] val, input logic strobe);
    @(negedge clk);
    cpuAddr = port; cpuData = val; ioWr = strobe;
    @(negedge clk);
    ioWr = 1'b0; cpuData = 8'h00;
  endtask

  task automatic testReset();
    checkLayout(0, "R1");
  endtask

  task automatic testOffsets();
    ioWrite(16'h7F00, 8'hC5, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cpuAddr = 16'(i * 16'h2AB7);
      #1;
      check({expBank(5, i * 16'h2AB7 >> 14 & 3), cpuAddr[13:0]}, "R2");
    end
  endtask

  task automatic testSwapLayouts();
    for (int s = 4; s < 8; s++) begin
      ioWrite(16'h7F10, 8'(8'hC0 + s), 1'b1);
      checkLayout(s, "R7");
    end
  endtask

  task automatic testAdvanced();
    ioWrite(16'h7FFF, 8'hC1, 1'b1); checkLayout(1, "R8");
    ioWrite(16'h7F00, 8'hC2, 1'b1); checkLayout(2, "R9");
    ioWrite(16'h7F42, 8'hC3, 1'b1); checkLayout(3, "R10");
  endtask

  task automatic testTiming();
    // R6: write layout 2 then read window 0 right after the edge.
    ioWrite(16'h7F00, 8'hC0, 1'b1);
    @(negedge clk);
    cpuAddr = 16'h7F00; cpuData = 8'hC2; ioWr = 1'b1;
    #1;
    check(17'h07F00, "R6 before edge");
    @(negedge clk);
    ioWr = 1'b0; cpuAddr = 16'h0123;
    #1;
    check({3'd4, 14'h0123}, "R6 after edge");
    for (int i = 0; i < 3; i++) @(negedge clk);
    cpuAddr = 16'hC001; #1;
    check({3'd7, 14'h0001}, "R6 hold");
  endtask

  task automatic testIgnored();
    ioWrite(16'h7F00, 8'hC6, 1'b1);
    ioWrite(16'h7F00, 8'h05, 1'b1);
    ioWrite(16'h7F00, 8'h83, 1'b1);
    ioWrite(16'h7F00, 8'h42, 1'b1);
    checkLayout(6, "R4");
    ioWrite(16'h7E00, 8'hC2, 1'b1);
    ioWrite(16'hFF00, 8'hC1, 1'b1);
    ioWrite(16'h7F00, 8'hC3, 1'b0);
    checkLayout(6, "R5");
  endtask

  task automatic testDontCare();
    ioWrite(16'h7F00, 8'hC9, 1'b1); checkLayout(1, "R11");
    ioWrite(16'h7F00, 8'hFC, 1'b1); checkLayout(4, "R11");
    ioWrite(16'h7F00, 8'hE8, 1'b1); checkLayout(0, "R11");
  endtask

  task automatic testResetAgain();
    ioWrite(16'h7F00, 8'hC2, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    checkLayout(0, "R1 rerun");
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testOffsets();
    testSwapLayouts();
    testAdvanced();
    testTiming();
    testIgnored();
    testDontCare();
    testResetAgain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule